// File: doc/BRIEF.md
# IOMMU Page Translation Engine

This block turns a device DMA address into a 36-bit physical address with a one-level page table held in system memory. A client hands it a 32-bit I/O virtual address and a direction flag. The engine works out where the page table entry lives from a table base value and a mapping window size, then fetches that 32-bit entry through a memory read port. It checks the entry and answers with a translated address and an access permission, or with a fault.

A fault also produces a one-cycle capture strobe carrying a fault status word and the faulting page address, plus an interrupt request strobe. A register block elsewhere keeps those values and holds the interrupt level. Only one translation is open at a time. Each of the three ports (request, memory read, response) uses a valid/ready style handshake. Caching of earlier translations and flushing are not part of this block.

Top module: `iopt_xlate_engine`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mem_req_valid`, `flt_capture` and `irq_req` are 0.
- R2: Window code c on `cfg_range` selects a window of 16 MiB << c ending at the top of the 32-bit space, so its start is 2^32 - 2^(24+c). The entry address is ({cfg_base, 4'h0} + ((va & ~start) >> 10 with its two low bits cleared)), 36 bits wide. `cfg_base` and `cfg_range` are sampled when the request is accepted.
- R3: An accepted request raises `mem_req_valid`. The request stays raised with a stable `mem_req_addr` until `mem_req_ready` is seen, and is then dropped. `req_ready` stays 0 from acceptance until the response has been taken.
- R4: The returned word is big-endian. Byte lane k, bits [8k+7:8k] of `mem_rsp_data`, holds the byte at entry address + k, and that byte is the entry's most significant byte when k is 0.
- R5: A translation that succeeds returns `rsp_pa` = {entry[31:8], va[11:0]}, `rsp_iova` = va with bits [11:0] cleared, and `rsp_mask` = 36'hFFF.
- R6: A translation that succeeds returns `rsp_perm` 2'b11 (read-write) when entry bit 2 is set, and 2'b01 (read-only) otherwise.
- R7: A translation faults when entry bit 1 (valid) is clear, or when a write request meets an entry with bit 2 clear. Entry bits 7 and 0 change nothing.
- R8: A faulting response carries `rsp_fault` 1, `rsp_perm` 2'b00, `rsp_pa` 0, `rsp_iova` 0 and an all-ones `rsp_mask`.
- R9: On a fault, `flt_capture` and `irq_req` are 1 for exactly the first cycle of `rsp_valid`. In that cycle `flt_status` = 32'hC0820000, with bit 18 (0x00040000) also set for a read, and `flt_addr` is the page-aligned va. On success, neither strobe fires.
- R10: `mem_rsp_err` set together with `mem_rsp_valid` is treated as an invalid entry, whatever the data.
- R11: `rsp_valid` and every response field hold steady until `rsp_ready` is seen. The engine then returns to accepting requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Page table base, in units of 16 bytes |
| cfg_range | input | 3 | Mapping window size code |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Engine idle, request taken |
| req_va | input | 32 | I/O virtual address |
| req_write | input | 1 | 1 for a write access |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Entry byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data, byte lane k = address + k |
| mem_rsp_err | input | 1 | Read ended in error |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Client takes the result |
| rsp_fault | output | 1 | Translation failed |
| rsp_perm | output | 2 | 00 none, 01 read-only, 11 read-write |
| rsp_pa | output | 36 | Translated physical address |
| rsp_iova | output | 32 | Page-aligned input address |
| rsp_mask | output | 36 | Offset mask of the mapping |
| flt_capture | output | 1 | Strobe: latch fault words |
| flt_status | output | 32 | Fault status word |
| flt_addr | output | 32 | Faulting page address |
| irq_req | output | 1 | Interrupt request strobe |

## Verification
A wrong window decode or base shift shows up as a wrong `mem_req_addr` in the first cycle after acceptance, before any data has returned. A lane swap, a misread flag bit or a bad fault decision shows up in the response fields, the permission and the strobes in the first cycle of `rsp_valid`, which is one cycle after the read data arrives. A state machine that loses track of the open transaction shows up as `req_ready` rising early, a repeated memory request, or a response that drops or changes before `rsp_ready`. The handshake assertions catch these within a cycle, and the bench stalls every port for an extra cycle to provoke them.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

  localparam int VA_W       = 32;
  localparam int WORD_W     = 32;
  localparam int BASE_SH    = 4;
  localparam int PA_W       = WORD_W + BASE_SH;
  localparam int PG_SH      = 12;
  localparam int RNG_W      = 3;
  localparam int WIN_MIN_SH = 24;
  localparam int PPN_LSB    = 8;
  localparam int PPN_W      = WORD_W - PPN_LSB;
  localparam int BIT_VALID  = 1;
  localparam int BIT_WRITE  = 2;
  localparam int LANES      = WORD_W / 8;

  localparam logic [WORD_W-1:0] FST_ANY    = 32'h8000_0000;
  localparam logic [WORD_W-1:0] FST_LATE   = 32'h4000_0000;
  localparam logic [WORD_W-1:0] FST_FIXED  = 32'h0080_0000;
  localparam logic [WORD_W-1:0] FST_READ   = 32'h0004_0000;
  localparam logic [WORD_W-1:0] FST_ADRVLD = 32'h0002_0000;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b11
  } perm_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RESP  = 2'd2
  } walk_st_e;

  // First address of the mapping window: 2^VA_W minus the window size.
  function automatic logic [VA_W-1:0] win_start(input logic [RNG_W-1:0] code);
    logic [VA_W:0] size;
    logic [VA_W:0] full;
    size = (VA_W+1)'(1) << (WIN_MIN_SH + int'(code));
    full = ((VA_W+1)'(1) << VA_W) - size;
    return full[VA_W-1:0];
  endfunction

  // Byte address of the table entry for one page.
  function automatic logic [PA_W-1:0] pte_addr(input logic [WORD_W-1:0] base,
                                               input logic [VA_W-1:0]   va,
                                               input logic [VA_W-1:0]   start);
    logic [VA_W-1:0] idx;
    logic [PA_W-1:0] off;
    idx = va & ~start;
    off = PA_W'(idx >> (PG_SH - 2)) & ~PA_W'(3);
    return (PA_W'(base) << BASE_SH) + off;
  endfunction

  // Lane 0 carries the lowest addressed byte, which is the most significant.
  function automatic logic [WORD_W-1:0] be_word(input logic [WORD_W-1:0] lanes);
    logic [WORD_W-1:0] w;
    for (int k = 0; k < LANES; k++) begin
      w[WORD_W-1-8*k -: 8] = lanes[8*k +: 8];
    end
    return w;
  endfunction

  function automatic logic [PA_W-1:0] phys_addr(input logic [PPN_W-1:0] ppn,
                                                input logic [PG_SH-1:0] off);
    return (PA_W'(ppn) << PG_SH) | PA_W'(off);
  endfunction

  function automatic logic [WORD_W-1:0] fault_status(input logic is_write);
    return FST_ANY | FST_LATE | FST_FIXED | FST_ADRVLD |
           (is_write ? '0 : FST_READ);
  endfunction

endpackage

// File: rtl/iopt_walk_addr.sv
module iopt_walk_addr
  import iopt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [WORD_W-1:0]   base,
  input  logic [RNG_W-1:0]    range_code,
  input  logic [VA_W-1:0]     va,
  output logic [PA_W-1:0]     ent_addr
);

  logic [VA_W-1:0] start_w;
  logic [PA_W-1:0] ent_addr_nxt;

  assign start_w      = win_start(range_code);
  assign ent_addr_nxt = pte_addr(base, va, start_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_addr <= '0;
    end else if (load) begin
      ent_addr <= ent_addr_nxt;
    end
  end

endmodule

// File: rtl/iopt_entry_eval.sv
module iopt_entry_eval
  import iopt_pkg::*;
(
  input  logic [WORD_W-1:0] rd_lanes,
  input  logic              rd_err,
  input  logic              is_write,
  input  logic [VA_W-1:0]   va,
  output logic              fault,
  output logic [1:0]        perm,
  output logic [PA_W-1:0]   pa,
  output logic [VA_W-1:0]   page_va,
  output logic [WORD_W-1:0] status
);

  logic [WORD_W-1:0] pte;
  logic              ent_valid;
  logic              ent_wr;
  logic              deny_write;

  assign pte        = be_word(rd_lanes);
  assign ent_valid  = pte[BIT_VALID] && !rd_err;
  assign ent_wr     = pte[BIT_WRITE];
  assign deny_write = is_write && !ent_wr;
  assign fault      = !ent_valid || deny_write;

  always_comb begin
    if (fault) begin
      perm = PERM_NONE;
    end else if (ent_wr) begin
      perm = PERM_RW;
    end else begin
      perm = PERM_RO;
    end
  end

  assign pa      = fault ? '0 : phys_addr(pte[WORD_W-1:PPN_LSB], va[PG_SH-1:0]);
  assign page_va = {va[VA_W-1:PG_SH], {PG_SH{1'b0}}};
  assign status  = fault_status(is_write);

endmodule

// File: rtl/iopt_walk_ctrl.sv
module iopt_walk_ctrl
  import iopt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              evt_accept,
  output logic [VA_W-1:0]   va_q,
  output logic              wr_q,
  input  logic              ev_fault,
  input  logic [1:0]        ev_perm,
  input  logic [PA_W-1:0]   ev_pa,
  input  logic [VA_W-1:0]   ev_page_va,
  input  logic [WORD_W-1:0] ev_status,
  output logic              rsp_fault,
  output logic [1:0]        rsp_perm,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [VA_W-1:0]   rsp_iova,
  output logic [PA_W-1:0]   rsp_mask,
  output logic              flt_capture,
  output logic [WORD_W-1:0] flt_status,
  output logic [VA_W-1:0]   flt_addr
);

  localparam logic [PA_W-1:0] PAGE_MASK = PA_W'((64'd1 << PG_SH) - 64'd1);

  walk_st_e state;
  logic     issued;
  logic     evt_mem_issue;
  logic     evt_mem_done;
  logic     evt_finish;

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_FETCH) && !issued;
  assign rsp_valid     = (state == ST_RESP);

  assign evt_accept    = req_valid && req_ready;
  assign evt_mem_issue = mem_req_valid && mem_req_ready;
  assign evt_mem_done  = (state == ST_FETCH) && issued && mem_rsp_valid;
  assign evt_finish    = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      issued <= 1'b0;
      va_q   <= '0;
      wr_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (evt_accept) begin
            state  <= ST_FETCH;
            issued <= 1'b0;
            va_q   <= req_va;
            wr_q   <= req_write;
          end
        end
        ST_FETCH: begin
          if (evt_mem_issue) begin
            issued <= 1'b1;
          end
          if (evt_mem_done) begin
            state  <= ST_RESP;
            issued <= 1'b0;
          end
        end
        ST_RESP: begin
          if (evt_finish) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_fault   <= 1'b0;
      rsp_perm    <= PERM_NONE;
      rsp_pa      <= '0;
      rsp_iova    <= '0;
      rsp_mask    <= '0;
      flt_capture <= 1'b0;
      flt_status  <= '0;
      flt_addr    <= '0;
    end else begin
      flt_capture <= evt_mem_done && ev_fault;
      if (evt_mem_done) begin
        rsp_fault <= ev_fault;
        rsp_perm  <= ev_perm;
        rsp_pa    <= ev_pa;
        rsp_iova  <= ev_fault ? '0 : ev_page_va;
        rsp_mask  <= ev_fault ? '1 : PAGE_MASK;
        if (ev_fault) begin
          flt_status <= ev_status;
          flt_addr   <= ev_page_va;
        end
      end
    end
  end

  assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

  assert_one_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !rsp_valid));

  assert_no_reissue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_mem_issue |=> !mem_req_valid);

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) &&
      $stable(rsp_perm) && $stable(rsp_fault) && $stable(rsp_iova)));

  assert_cap_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flt_capture |=> !flt_capture);

  assert_cap_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flt_capture |-> (rsp_valid && rsp_fault && $rose(rsp_valid)));

endmodule

// File: rtl/iopt_xlate_engine.sv
module iopt_xlate_engine
  import iopt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cfg_base,
  input  logic [RNG_W-1:0]  cfg_range,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [1:0]        rsp_perm,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [VA_W-1:0]   rsp_iova,
  output logic [PA_W-1:0]   rsp_mask,
  output logic              flt_capture,
  output logic [WORD_W-1:0] flt_status,
  output logic [VA_W-1:0]   flt_addr,
  output logic              irq_req
);

  logic              evt_accept;
  logic [VA_W-1:0]   va_q;
  logic              wr_q;
  logic              ev_fault;
  logic [1:0]        ev_perm;
  logic [PA_W-1:0]   ev_pa;
  logic [VA_W-1:0]   ev_page_va;
  logic [WORD_W-1:0] ev_status;

  iopt_walk_addr u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (evt_accept),
    .base       (cfg_base),
    .range_code (cfg_range),
    .va         (req_va),
    .ent_addr   (mem_req_addr)
  );

  iopt_entry_eval u_eval (
    .rd_lanes (mem_rsp_data),
    .rd_err   (mem_rsp_err),
    .is_write (wr_q),
    .va       (va_q),
    .fault    (ev_fault),
    .perm     (ev_perm),
    .pa       (ev_pa),
    .page_va  (ev_page_va),
    .status   (ev_status)
  );

  iopt_walk_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .req_write     (req_write),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .evt_accept    (evt_accept),
    .va_q          (va_q),
    .wr_q          (wr_q),
    .ev_fault      (ev_fault),
    .ev_perm       (ev_perm),
    .ev_pa         (ev_pa),
    .ev_page_va    (ev_page_va),
    .ev_status     (ev_status),
    .rsp_fault     (rsp_fault),
    .rsp_perm      (rsp_perm),
    .rsp_pa        (rsp_pa),
    .rsp_iova      (rsp_iova),
    .rsp_mask      (rsp_mask),
    .flt_capture   (flt_capture),
    .flt_status    (flt_status),
    .flt_addr      (flt_addr)
  );

  assign irq_req = flt_capture;

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

  assert_fault_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_perm == 2'b00 && rsp_pa == '0));

  assert_grant_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_perm == 2'b01 || rsp_perm == 2'b11));

  assert_write_needs_rw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault && wr_q) |-> rsp_perm == 2'b11);

  assert_aligned_iova_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_iova[PG_SH-1:0] == '0);

endmodule

// File: tb/iopt_xlate_engine_bench.sv
module iopt_xlate_engine_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [2:0]  cfg_range = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [35:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic [1:0]  rsp_perm;
  logic [35:0] rsp_pa;
  logic [31:0] rsp_iova;
  logic [35:0] rsp_mask;
  logic        flt_capture;
  logic [31:0] flt_status;
  logic [31:0] flt_addr;
  logic        irq_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iopt_xlate_engine u_iopt_xlate_engine (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_range(cfg_range),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_err(mem_rsp_err), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_perm(rsp_perm), .rsp_pa(rsp_pa),
    .rsp_iova(rsp_iova), .rsp_mask(rsp_mask), .flt_capture(flt_capture),
    .flt_status(flt_status), .flt_addr(flt_addr), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 invalid entry, 1 read-only, 2 read-write, 3 memory error
  task automatic xact(input logic [31:0] base, input logic [2:0] rng,
                      input logic [31:0] va, input bit wr, input int kind);
    logic [31:0] start, entry, lanes, stat;
    logic [35:0] ea, pa;
    logic [23:0] ppn;
    logic [7:0]  flags;
    bit          flt;
    start = 32'hFFFF_FFFF << (24 + rng);
    ea    = {base, 4'h0} + ((36'(va & ~start) >> 12) * 36'd4);
    ppn   = ea[25:2] ^ 24'hC3A51E;
    case (kind)
      0:       flags = 8'h85;
      1:       flags = 8'h83;
      2:       flags = 8'h06;
      default: flags = 8'h87;
    endcase
    entry = {ppn, flags};
    for (int k = 0; k < 4; k++) lanes[8*k +: 8] = entry[31-8*k -: 8];
    flt  = (kind == 0) || (kind == 3) || (wr && kind == 1);
    pa   = {ppn, va[11:0]};
    stat = 32'hC082_0000 | (wr ? 32'h0 : 32'h0004_0000);

    @(negedge clk);
    cfg_base = base; cfg_range = rng; req_va = va; req_write = wr; req_valid = 1'b1;
    chk("R3 ready before accept", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_base = ~base; cfg_range = ~rng;
    chk("R3 busy after accept", 64'(req_ready), 64'd0);
    chk("R3 read issued", 64'(mem_req_valid), 64'd1);
    chk("R2 entry address", 64'(mem_req_addr), 64'(ea));
    @(posedge clk);
    @(negedge clk);
    chk("R3 read held", 64'(mem_req_valid), 64'd1);
    chk("R2 entry address held", 64'(mem_req_addr), 64'(ea));
    mem_req_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R3 read dropped", 64'(mem_req_valid), 64'd0);
    chk("R3 no early response", 64'(rsp_valid), 64'd0);
    mem_rsp_valid = 1'b1; mem_rsp_data = lanes; mem_rsp_err = (kind == 3);
    @(posedge clk);
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = 32'hDEAD_BEEF;
    chk("R11 response present", 64'(rsp_valid), 64'd1);
    chk("R7 R10 fault decision", 64'(rsp_fault), 64'(flt));
    if (flt) begin
      chk("R8 perm none", 64'(rsp_perm), 64'd0);
      chk("R8 pa zero", 64'(rsp_pa), 64'd0);
      chk("R8 iova zero", 64'(rsp_iova), 64'd0);
      chk("R8 mask ones", 64'(rsp_mask), 64'hF_FFFF_FFFF);
      chk("R9 capture strobe", 64'(flt_capture), 64'd1);
      chk("R9 irq strobe", 64'(irq_req), 64'd1);
      chk("R9 status word", 64'(flt_status), 64'(stat));
      chk("R9 fault page", 64'(flt_addr), 64'(va & 32'hFFFF_F000));
    end else begin
      chk("R4 R5 translated pa", 64'(rsp_pa), 64'(pa));
      chk("R6 permission", 64'(rsp_perm), (kind == 2) ? 64'd3 : 64'd1);
      chk("R5 iova", 64'(rsp_iova), 64'(va & 32'hFFFF_F000));
      chk("R5 mask", 64'(rsp_mask), 64'hFFF);
      chk("R9 no capture", 64'(flt_capture), 64'd0);
      chk("R9 no irq", 64'(irq_req), 64'd0);
    end
    @(posedge clk);
    @(negedge clk);
    chk("R11 response held", 64'(rsp_valid), 64'd1);
    chk("R11 pa held", 64'(rsp_pa), flt ? 64'd0 : 64'(pa));
    chk("R9 capture one cycle", 64'(flt_capture), 64'd0);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R11 response released", 64'(rsp_valid), 64'd0);
    chk("R11 idle again", 64'(req_ready), 64'd1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset req_ready", 64'(req_ready), 64'd1);
    chk("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk("R1 reset strobes", 64'({flt_capture, irq_req}), 64'd0);
    for (int r = 0; r < 8; r++) begin
      for (int v = 0; v < 4; v++) begin
        for (int w = 0; w < 2; w++) begin
          logic [31:0] va;
          case (v)
            0:       va = 32'hFFFF_F123;
            1:       va = 32'h8000_0ABC;
            2:       va = 32'hF123_4567 ^ (32'(r) << 20);
            default: va = 32'h0000_0FFF | (32'(r) << 24);
          endcase
          xact(32'h0012_3400 + 32'(r) * 32'h0101_0100, 3'(r), va, w[0],
               (v + w + r) % 4);
        end
      end
    end
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hang expected=done");
      summary();
    end
  end

endmodule